// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the host-side master for a delta-sigma converter that has a byte-oriented serial port. On a request it shifts out a command byte that selects single or continuous conversion and one of eight setups. It then keeps the serial clock parked while the converter's data output is high, because that line going low means a result is ready. Once the line is low it runs a 40-clock read frame. The first eight clocks carry a control code on the master's data output, and the last 32 clocks shift the result in, most significant bit first.

In continuous mode the reader goes on collecting words until a stop is requested. It then puts the all-ones leave code into the next frame's prefix, still reads that final word, and goes back to idle. After a move to a different physical channel, after a single conversion, or after reset, the converter's filter needs several words to flush. The reader drops that many words (three at the normal rate, five at the high rate) and raises a one-cycle valid strobe only for the words it keeps. A wait timer reports a converter that never signals ready.

Top module: `adc_conv_reader`

## Requirements
- R1: The command byte goes out MSB first as {1, continuous, setup[2:0], 000}, so continuous on setup code 010 sends 11010000.
- R2: After the command byte, no serial clock edge is produced until `sdo` has been seen low.
- R3: A read frame has 40 serial clocks. `resultData` holds the bits sampled on clocks 9 to 40, and the bit from clock 9 is bit 31.
- R4: A single-conversion read sends 00000000 in its prefix, delivers one word and returns to idle.
- R5: Each continuous read that is not the last one sends 00000000 in its prefix. The reader then waits for `sdo` to go high and low again before it reads the next word.
- R6: After `reqStop` is pulsed in continuous mode, the next frame sends 11111111 in its prefix, its word is still delivered unless it is being discarded, and the block then goes idle.
- R7: A continuous run discards its first 3 words when `rateHigh`=0 and its first 5 when `rateHigh`=1, if it starts after reset, after a single conversion, after a timeout, or on a different `reqChannel` than the previous continuous run.
- R8: A continuous run on the same `reqChannel` as the previous continuous run, with no single conversion or timeout in between, discards no words.
- R9: `resultValid` is a one-cycle pulse and is never raised for a discarded word.
- R10: If `sdo` does not show the expected level within TIMEOUT_CYCLES clocks while waiting, `timeoutErr` is set and the block goes idle with `sclk` high. The next `reqStart` clears `timeoutErr`.
- R11: `sclk` idles high and each of its phases lasts HALF_PERIOD clocks. `sdi` changes only where `sclk` falls, and `sdi` is low while idle.
- R12: `reqStart` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start a conversion request (taken only when idle) |
| reqContinuous | input | 1 | 1 for continuous conversion, 0 for single |
| reqSetup | input | 3 | Setup pointer placed in the command byte |
| reqChannel | input | CHAN_W | Physical channel that the chosen setup addresses |
| rateHigh | input | 1 | Output rate is at or above 3200 samples/s |
| reqStop | input | 1 | Pulse to leave continuous mode after the next word |
| sdo | input | 1 | Converter serial data and ready flag |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Serial data to the converter |
| busy | output | 1 | Request in progress |
| resultData | output | DATA_W | Last kept conversion word |
| resultValid | output | 1 | One-cycle strobe for a new kept word |
| timeoutErr | output | 1 | Converter did not signal in time |

## Verification
A wrong discard count or a lost record of the previous channel shows up as an extra or missing `resultValid` pulse. That appears within the first few words of a continuous run, so each run compares the exact list of delivered words against the run's channel history. A bit counter that is off shows up in the same frame as a misplaced prefix code on `sdi` or as shifted result data. A waiting state that never leaves shows up TIMEOUT_CYCLES later as `timeoutErr`, and an early clock shows up as an `sclk` fall before `sdo` has gone low.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Protocol constants fixed by the converter's byte-oriented port
  localparam int CODE_W  = 8;
  localparam int SETUP_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT_RDY,
    ST_READ,
    ST_WAIT_REL
  } rdState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              startCmd;
    logic              startRead;
    logic              exitCode;
    logic              latchResult;
    logic [CODE_W-1:0] cmdByte;
  } dpCtrl_t;

endpackage

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              sdo,
  output logic              sclk,
  output logic              sdi,
  output logic              frameDone,
  output logic [DATA_W-1:0] resultData
);

  localparam int FRAME_W = CODE_W + DATA_W;
  localparam int BIT_CW  = $clog2(FRAME_W + 1);
  localparam int HALF_CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic              active;
  logic              sclkR;
  logic              sdiR;
  logic              doneR;
  logic [HALF_CW-1:0] halfCnt;
  logic [BIT_CW-1:0]  bitCnt;
  logic [BIT_CW-1:0]  bitLast;
  logic [CODE_W-1:0]  txReg;
  logic [DATA_W-1:0]  rxReg;
  logic [DATA_W-1:0]  resultR;
  logic               halfEnd;

  assign halfEnd = (halfCnt == HALF_CW'(HALF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      sclkR   <= 1'b1;
      sdiR    <= 1'b0;
      doneR   <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      bitLast <= '0;
      txReg   <= '0;
      rxReg   <= '0;
      resultR <= '0;
    end else begin
      doneR <= 1'b0;
      if (ctrl.latchResult) resultR <= rxReg;
      if (!active) begin
        sclkR <= 1'b1;
        sdiR  <= 1'b0;
        if (ctrl.startCmd || ctrl.startRead) begin
          active  <= 1'b1;
          halfCnt <= '0;
          bitCnt  <= '0;
          if (ctrl.startCmd) begin
            txReg   <= ctrl.cmdByte;
            bitLast <= BIT_CW'(CODE_W - 1);
          end else begin
            txReg   <= ctrl.exitCode ? {CODE_W{1'b1}} : '0;
            bitLast <= BIT_CW'(FRAME_W - 1);
          end
        end
      end else if (halfEnd) begin
        halfCnt <= '0;
        if (sclkR) begin
          // falling edge: present next outgoing bit
          sclkR <= 1'b0;
          sdiR  <= txReg[CODE_W-1];
          txReg <= {txReg[CODE_W-2:0], 1'b0};
        end else begin
          // rising edge: take incoming bit
          sclkR  <= 1'b1;
          rxReg  <= {rxReg[DATA_W-2:0], sdo};
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == bitLast) begin
            active <= 1'b0;
            doneR  <= 1'b1;
            sdiR   <= 1'b0;
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign sclk       = sclkR;
  assign sdi        = sdiR;
  assign frameDone  = doneR;
  assign resultData = resultR;

endmodule

// File: rtl/adc_rd_control.sv
module adc_rd_control
  import adc_rd_pkg::*;
#(
  parameter int CHAN_W         = 2,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int SLOW_DISCARD   = 3,
  parameter int FAST_DISCARD   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqStart,
  input  logic               reqContinuous,
  input  logic [SETUP_W-1:0] reqSetup,
  input  logic [CHAN_W-1:0]  reqChannel,
  input  logic               rateHigh,
  input  logic               reqStop,
  input  logic               sdo,
  input  logic               frameDone,
  output dpCtrl_t            ctrl,
  output logic               busy,
  output logic               resultValid,
  output logic               timeoutErr
);

  localparam int TIMER_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int DISC_MAX = (FAST_DISCARD > SLOW_DISCARD) ? FAST_DISCARD : SLOW_DISCARD;
  localparam int DISC_W   = $clog2(DISC_MAX + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(TIMEOUT_CYCLES - 1);

  rdState_e           state;
  logic               sdoMeta;
  logic               sdoSync;
  logic               contR;
  logic               exitR;
  logic               stopPending;
  logic               histValid;
  logic [CHAN_W-1:0]  lastChan;
  logic [DISC_W-1:0]  discardCnt;
  logic [TIMER_W-1:0] timer;
  logic               needFlush;
  logic               timerEnd;

  assign needFlush = !histValid || (reqChannel != lastChan);
  assign timerEnd  = (timer == TIMER_LAST);

  // Strobes to datapath
  always_comb begin
    ctrl = '0;
    ctrl.cmdByte = {1'b1, reqContinuous, reqSetup, 3'b000};
    case (state)
      ST_IDLE:     ctrl.startCmd = reqStart;
      ST_WAIT_RDY: begin
        ctrl.startRead = !sdoSync;
        ctrl.exitCode  = contR && stopPending;
      end
      ST_READ:     ctrl.latchResult = frameDone && (discardCnt == '0);
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sdoMeta     <= 1'b1;
      sdoSync     <= 1'b1;
      contR       <= 1'b0;
      exitR       <= 1'b0;
      stopPending <= 1'b0;
      histValid   <= 1'b0;
      lastChan    <= '0;
      discardCnt  <= '0;
      timer       <= '0;
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      sdoMeta     <= sdo;
      sdoSync     <= sdoMeta;
      resultValid <= 1'b0;
      if (reqStop && contR && (state != ST_IDLE)) stopPending <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (reqStart) begin
            state       <= ST_CMD;
            contR       <= reqContinuous;
            timeoutErr  <= 1'b0;
            stopPending <= 1'b0;
            if (reqContinuous) begin
              discardCnt <= needFlush ? (rateHigh ? DISC_W'(FAST_DISCARD) : DISC_W'(SLOW_DISCARD)) : '0;
              histValid  <= 1'b1;
              lastChan   <= reqChannel;
            end else begin
              discardCnt <= '0;
              histValid  <= 1'b0;
            end
          end
        end
        ST_CMD: begin
          if (frameDone) begin
            state <= ST_WAIT_RDY;
            timer <= '0;
          end
        end
        ST_WAIT_RDY: begin
          if (!sdoSync) begin
            state <= ST_READ;
            exitR <= contR && stopPending;
            if (contR && stopPending) stopPending <= 1'b0;
          end else if (timerEnd) begin
            state      <= ST_IDLE;
            timeoutErr <= 1'b1;
            histValid  <= 1'b0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_READ: begin
          if (frameDone) begin
            if (discardCnt == '0) resultValid <= 1'b1;
            else                  discardCnt  <= discardCnt - 1'b1;
            if (!contR || exitR) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_WAIT_REL;
              timer <= '0;
            end
          end
        end
        ST_WAIT_REL: begin
          if (sdoSync) begin
            state <= ST_WAIT_RDY;
            timer <= '0;
          end else if (timerEnd) begin
            state      <= ST_IDLE;
            timeoutErr <= 1'b1;
            histValid  <= 1'b0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/adc_conv_reader.sv
module adc_conv_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_PERIOD    = 4,
  parameter int DATA_W         = 32,
  parameter int CHAN_W         = 2,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int SLOW_DISCARD   = 3,
  parameter int FAST_DISCARD   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqStart,
  input  logic               reqContinuous,
  input  logic [SETUP_W-1:0] reqSetup,
  input  logic [CHAN_W-1:0]  reqChannel,
  input  logic               rateHigh,
  input  logic               reqStop,
  input  logic               sdo,
  output logic               sclk,
  output logic               sdi,
  output logic               busy,
  output logic [DATA_W-1:0]  resultData,
  output logic               resultValid,
  output logic               timeoutErr
);

  dpCtrl_t dpCtrl;
  logic    frameDone;

  adc_rd_control #(
    .CHAN_W        (CHAN_W),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SLOW_DISCARD  (SLOW_DISCARD),
    .FAST_DISCARD  (FAST_DISCARD)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqStart     (reqStart),
    .reqContinuous(reqContinuous),
    .reqSetup     (reqSetup),
    .reqChannel   (reqChannel),
    .rateHigh     (rateHigh),
    .reqStop      (reqStop),
    .sdo          (sdo),
    .frameDone    (frameDone),
    .ctrl         (dpCtrl),
    .busy         (busy),
    .resultValid  (resultValid),
    .timeoutErr   (timeoutErr)
  );

  adc_rd_datapath #(
    .HALF_PERIOD(HALF_PERIOD),
    .DATA_W     (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .sdo       (sdo),
    .sclk      (sclk),
    .sdi       (sdi),
    .frameDone (frameDone),
    .resultData(resultData)
  );

endmodule

// File: rtl/adc_conv_reader_chk.sv
module adc_conv_reader_chk (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic sdi,
  input logic busy,
  input logic resultValid,
  input logic timeoutErr
);

  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk && !sdi));

  // R11
  sdi_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdi));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R10
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> (!busy && sclk));

  // R10
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && !busy) |=> (timeoutErr || busy));

endmodule

bind adc_conv_reader adc_conv_reader_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclk       (sclk),
  .sdi        (sdi),
  .busy       (busy),
  .resultValid(resultValid),
  .timeoutErr (timeoutErr)
);

// File: tb/tb_adc_conv_reader.sv
module tb_adc_conv_reader;

  localparam int HALF    = 3;
  localparam int TIMEOUT = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0;
  logic        reqContinuous = 1'b0;
  logic [2:0]  reqSetup = '0;
  logic [1:0]  reqChannel = '0;
  logic        rateHigh = 1'b0;
  logic        reqStop = 1'b0;
  logic        sdo = 1'b1;
  logic        sclk;
  logic        sdi;
  logic        busy;
  logic [31:0] resultData;
  logic        resultValid;
  logic        timeoutErr;

  int checks = 0;
  int errors = 0;
  int fallCnt = 0;
  int lowRun = 0;
  int lowSeen = 0;
  int widthBad = 0;
  int pulseBad = 0;
  logic prevV = 1'b0;
  logic [31:0] gotQ[$];

  always #2.5 clk = ~clk;

  adc_conv_reader #(
    .HALF_PERIOD(HALF),
    .TIMEOUT_CYCLES(TIMEOUT)
  ) dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqContinuous(reqContinuous),
    .reqSetup(reqSetup), .reqChannel(reqChannel), .rateHigh(rateHigh),
    .reqStop(reqStop), .sdo(sdo), .sclk(sclk), .sdi(sdi), .busy(busy),
    .resultData(resultData), .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  always @(negedge sclk) fallCnt++;

  always @(posedge clk) begin
    if (rstN) begin
      if (!sclk) lowRun++;
      else if (lowRun != 0) begin
        if (lowRun != HALF) widthBad++;
        lowSeen++;
        lowRun = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (resultValid) gotQ.push_back(resultData);
    if (resultValid && prevV) pulseBad++;
    prevV = resultValid;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input bit cont, input logic [2:0] setup,
                            input logic [1:0] chan, input bit fast);
    @(negedge clk);
    reqContinuous = cont; reqSetup = setup; reqChannel = chan; rateHigh = fast;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
  endtask

  task automatic captureCmd(output logic [7:0] cmd);
    cmd = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk);
      @(negedge clk);
      cmd = {cmd[6:0], sdi};
    end
    @(posedge sclk);
  endtask

  // converter side of one 40-clock frame; sdo must already be low
  task automatic readFrame(input logic [31:0] word, output logic [7:0] prefix);
    prefix = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge sclk);
      sdo = (i >= 8) ? word[39-i] : 1'b0;
      @(negedge clk);
      if (i < 8) prefix = {prefix[6:0], sdi};
    end
    @(posedge sclk);
    @(negedge clk);
    sdo = 1'b1;
  endtask

  task automatic testReset();
    check(sclk == 1'b1, "R11", "idle sclk", 64'(sclk), 64'd1);
    check(sdi == 1'b0, "R11", "idle sdi", 64'(sdi), 64'd0);
    check(busy == 1'b0, "R12", "idle busy", 64'(busy), 64'd0);
    check(resultValid == 1'b0, "R9", "idle valid", 64'(resultValid), 64'd0);
    check(timeoutErr == 1'b0, "R10", "idle timeout", 64'(timeoutErr), 64'd0);
  endtask

  task automatic testSingle(input logic [2:0] setup, input logic [1:0] chan,
                            input logic [31:0] word);
    logic [7:0] cmd;
    logic [7:0] prefix;
    int f0;
    gotQ.delete();
    pulseStart(1'b0, setup, chan, 1'b0);
    captureCmd(cmd);
    check(cmd == {1'b1, 1'b0, setup, 3'b000}, "R1", "single cmd byte", 64'(cmd),
          64'({1'b1, 1'b0, setup, 3'b000}));
    f0 = fallCnt;
    repeat (20) @(negedge clk);
    // R12: a start while busy must not disturb the transfer
    reqContinuous = 1'b1; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0; reqContinuous = 1'b0;
    repeat (20) @(negedge clk);
    check(fallCnt == f0, "R2", "sclk falls before ready", 64'(fallCnt - f0), 64'd0);
    sdo = 1'b0;
    readFrame(word, prefix);
    check(prefix == 8'h00, "R4", "single prefix", 64'(prefix), 64'h00);
    repeat (10) @(negedge clk);
    check(gotQ.size() == 1, "R4", "single word count", 64'(gotQ.size()), 64'd1);
    if (gotQ.size() >= 1)
      check(gotQ[0] == word, "R3", "single data", 64'(gotQ[0]), 64'(word));
    check(busy == 1'b0, "R12", "idle after single with ignored start", 64'(busy), 64'd0);
    check(fallCnt - f0 == 40, "R3", "read frame clocks", 64'(fallCnt - f0), 64'd40);
  endtask

  task automatic testCont(input logic [2:0] setup, input logic [1:0] chan,
                          input bit fast, input int n, input int expDisc,
                          input logic [31:0] base, input string req);
    logic [7:0] cmd;
    logic [7:0] prefix;
    int expCnt;
    gotQ.delete();
    pulseStart(1'b1, setup, chan, fast);
    captureCmd(cmd);
    check(cmd == {1'b1, 1'b1, setup, 3'b000}, "R1", "cont cmd byte", 64'(cmd),
          64'({1'b1, 1'b1, setup, 3'b000}));
    for (int k = 0; k < n; k++) begin
      repeat (40) @(negedge clk);
      if (k == n - 1) begin
        reqStop = 1'b1;
        @(negedge clk);
        reqStop = 1'b0;
        @(negedge clk);
      end
      sdo = 1'b0;
      readFrame(base + 32'(k), prefix);
      if (k == n - 1)
        check(prefix == 8'hFF, "R6", "leave prefix", 64'(prefix), 64'hFF);
      else
        check(prefix == 8'h00, "R5", "stay prefix", 64'(prefix), 64'h00);
    end
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R6", "idle after leave", 64'(busy), 64'd0);
    expCnt = (n > expDisc) ? (n - expDisc) : 0;
    check(gotQ.size() == expCnt, req, "kept word count", 64'(gotQ.size()), 64'(expCnt));
    for (int j = 0; j < expCnt && j < gotQ.size(); j++)
      check(gotQ[j] == base + 32'(expDisc + j), req, "kept word data", 64'(gotQ[j]),
            64'(base + 32'(expDisc + j)));
  endtask

  task automatic testTimeout();
    logic [7:0] cmd;
    pulseStart(1'b0, 3'd5, 2'd0, 1'b0);
    captureCmd(cmd);
    repeat (TIMEOUT + 20) @(negedge clk);
    check(timeoutErr == 1'b1, "R10", "timeout flag", 64'(timeoutErr), 64'd1);
    check(busy == 1'b0, "R10", "idle after timeout", 64'(busy), 64'd0);
    check(sclk == 1'b1, "R10", "sclk high after timeout", 64'(sclk), 64'd1);
    testSingle(3'd6, 2'd0, 32'h1357_9BDF);
    check(timeoutErr == 1'b0, "R10", "flag cleared by new start", 64'(timeoutErr), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testSingle(3'd0, 2'd3, 32'hA5C3_0F96);
    // R7: follows a single conversion, normal rate
    testCont(3'd2, 2'd0, 1'b0, 5, 3, 32'h1000_0000, "R7");
    // R8: same channel as previous continuous run
    testCont(3'd2, 2'd0, 1'b0, 3, 0, 32'h2000_0000, "R8");
    // R7: channel change, high rate
    testCont(3'd4, 2'd1, 1'b1, 7, 5, 32'h3000_0000, "R7");
    // R8: same channel, leave on first word
    testCont(3'd4, 2'd1, 1'b1, 1, 0, 32'h4000_0000, "R8");
    testTimeout();
    // R9: leave while still discarding, no strobe
    testCont(3'd7, 2'd2, 1'b0, 2, 3, 32'h5000_0000, "R9");
    check(pulseBad == 0, "R9", "valid wider than one cycle", 64'(pulseBad), 64'd0);
    check(widthBad == 0 && lowSeen > 0, "R11", "sclk low phase width", 64'(widthBad), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule